// File: doc/BRIEF.md
# ATR Arrival Window Monitor

This block measures when a smart card starts its answer-to-reset (ATR) in asynchronous mode. A sequencer pulses `start_i` on the cycle it releases card reset. From then on the block counts card clock cycles, which are marked by `card_clk_en_i`. The first falling edge on the card IO line after that point is judged against two thresholds. An edge below the early threshold is too early. An edge at or above the early threshold and below the mute threshold is a valid ATR start. If no edge arrives before the count reaches the mute threshold, the card is mute.

Too-early and mute results are held in sticky flags. A read of the status register clears them, and either flag raises the interrupt request. A valid ATR start produces a single-cycle pulse. The mute case also gives the sequencer a single-cycle timeout pulse, so that it can start deactivation.

Both thresholds reach the block as the raw bytes of their host registers. The early threshold is 10 bits and the mute threshold is 16 bits.

Top module: `atr_window_mon`

## Requirements
- R1: After reset, `early_o`, `mute_o`, `irq_o`, `atr_valid_o` and `timeout_o` are all low, and no run is in progress.
- R2: The early threshold is `{early_hi_i, early_lo_i[7:6]}` (10 bits); bits [5:0] of `early_lo_i` have no effect. The mute threshold is `{mute_hi_i, mute_lo_i}` (16 bits). The register reset values 0xAA/0x00 give 680 cycles, and 0xA4/0x74 give 42100 cycles.
- R3: A start pulse sets the cycle count to zero. The count then advances by one on each clock cycle with `card_clk_en_i` high, and it holds while `card_clk_en_i` is low.
- R4: IO passes through a two-flop synchronizer, and only a high-to-low transition counts as an ATR start. With `card_clk_en_i` held high, an IO fall driven just after the k-th clock edge that follows the start edge is judged with a count of k+2. Falls seen while no run is in progress are ignored.
- R5: A judged fall with a count below the early threshold sets `early_o` and produces no `atr_valid_o` pulse.
- R6: A judged fall with a count of at least the early threshold and below the mute threshold gives a one-cycle `atr_valid_o` pulse and sets no flag.
- R7: If the count reaches the mute threshold before any fall, one cycle later `mute_o` is set and `timeout_o` pulses for one cycle. Counting then stops, and later IO edges are ignored until the next start.
- R8: `early_o` and `mute_o` stay set until a cycle with `status_rd_i` high clears them. A flag event in the same cycle as the read leaves the flag set.
- R9: `irq_o` is high exactly when `early_o` or `mute_o` is high.
- R10: A start pulse that arrives while a flag is set leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse on the cycle card reset is released |
| card_clk_en_i | input | 1 | High on cycles that carry a card clock edge |
| io_i | input | 1 | Card IO level, asynchronous |
| status_rd_i | input | 1 | Status register read strobe; clears the flags |
| early_hi_i | input | 8 | Early threshold, upper eight bits |
| early_lo_i | input | 8 | Early threshold low byte; only bits [7:6] are used |
| mute_hi_i | input | 8 | Mute threshold, upper byte |
| mute_lo_i | input | 8 | Mute threshold, lower byte |
| early_o | output | 1 | Sticky too-early flag |
| mute_o | output | 1 | Sticky mute flag |
| irq_o | output | 1 | Interrupt request |
| atr_valid_o | output | 1 | One-cycle pulse on an in-window ATR start |
| timeout_o | output | 1 | One-cycle pulse when the mute threshold expires |

## Verification
The bench builds the block with its default synchronizer depth of two stages, which fixes the judged count at two more than the drive offset. That offset lets it place an IO fall exactly one count below each threshold and exactly on it. Small programmed thresholds cover the early, valid, mute, clock-gating, sticky and read-collision cases in a few hundred cycles. With the card clock enable held high, the register reset values of 680 and 42100 cycles also become reachable, so both boundaries are exercised at their reset values.

// File: rtl/atrw_pkg.sv
`timescale 1ns/1ps
package atrw_pkg;
  localparam int BYTE_W     = 8;
  localparam int EARLY_W    = 10;
  localparam int MUTE_W     = 16;
  localparam int EARLY_LO_W = EARLY_W - BYTE_W;

  typedef logic [MUTE_W-1:0]  cnt_t;
  typedef logic [EARLY_W-1:0] early_thr_t;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_EARLY = 2'd1,
    EV_VALID = 2'd2,
    EV_MUTE  = 2'd3
  } atr_ev_e;
endpackage

// File: rtl/atrw_io_sync.sv
`timescale 1ns/1ps
module atrw_io_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_i,
  output logic fall_o
);
  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], io_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/atrw_cycle_counter.sv
`timescale 1ns/1ps
module atrw_cycle_counter
  import atrw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic cke_i,
  input  cnt_t limit_i,
  output cnt_t cnt_o,
  output logic at_limit_o
);
  cnt_t cnt_q;
  cnt_t cnt_d;
  logic adv;

  assign at_limit_o = (cnt_q >= limit_i);
  assign adv        = run_i & cke_i & ~at_limit_o;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/atrw_classify.sv
`timescale 1ns/1ps
module atrw_classify
  import atrw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fall_i,
  input  logic       at_limit_i,
  input  cnt_t       cnt_i,
  input  early_thr_t early_thr_i,
  input  logic       status_rd_i,
  output logic       active_o,
  output logic       early_o,
  output logic       mute_o,
  output logic       valid_o,
  output logic       timeout_o
);
  logic    active_q, active_d;
  logic    early_q, early_d;
  logic    mute_q, mute_d;
  logic    valid_q, timeout_q;
  atr_ev_e ev;

  // event decision: start has priority, then expiry, then the IO fall
  always_comb begin
    ev       = EV_NONE;
    active_d = active_q;
    if (start_i) begin
      active_d = 1'b1;
    end else if (active_q) begin
      if (at_limit_i) begin
        ev       = EV_MUTE;
        active_d = 1'b0;
      end else if (fall_i) begin
        ev       = (cnt_i < cnt_t'(early_thr_i)) ? EV_EARLY : EV_VALID;
        active_d = 1'b0;
      end
    end
  end

  // sticky flags: a read clears, a new event in the same cycle wins
  always_comb begin
    early_d = (early_q & ~status_rd_i) | (ev == EV_EARLY);
    mute_d  = (mute_q  & ~status_rd_i) | (ev == EV_MUTE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      early_q   <= 1'b0;
      mute_q    <= 1'b0;
      valid_q   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      early_q   <= early_d;
      mute_q    <= mute_d;
      valid_q   <= (ev == EV_VALID);
      timeout_q <= (ev == EV_MUTE);
    end
  end

  assign active_o  = active_q;
  assign early_o   = early_q;
  assign mute_o    = mute_q;
  assign valid_o   = valid_q;
  assign timeout_o = timeout_q;
endmodule

// File: rtl/atr_window_mon.sv
`timescale 1ns/1ps
module atr_window_mon
  import atrw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        card_clk_en_i,
  input  logic        io_i,
  input  logic        status_rd_i,
  input  logic [7:0]  early_hi_i,
  input  logic [7:0]  early_lo_i,
  input  logic [7:0]  mute_hi_i,
  input  logic [7:0]  mute_lo_i,
  output logic        early_o,
  output logic        mute_o,
  output logic        irq_o,
  output logic        atr_valid_o,
  output logic        timeout_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // threshold assembly from the host register bytes
  early_thr_t early_thr;
  cnt_t       mute_thr;
  logic       unused_lo_bits;
  assign early_thr      = {early_hi_i, early_lo_i[BYTE_W-1 -: EARLY_LO_W]};
  assign mute_thr       = {mute_hi_i, mute_lo_i};
  assign unused_lo_bits = ^early_lo_i[BYTE_W-EARLY_LO_W-1:0];

  logic io_fall;
  logic active;
  logic at_limit;
  cnt_t cnt;

  atrw_io_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .io_i   (io_i),
    .fall_o (io_fall)
  );

  atrw_cycle_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clr_i      (start_i),
    .run_i      (active),
    .cke_i      (card_clk_en_i),
    .limit_i    (mute_thr),
    .cnt_o      (cnt),
    .at_limit_o (at_limit)
  );

  atrw_classify u_cls (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .fall_i      (io_fall),
    .at_limit_i  (at_limit),
    .cnt_i       (cnt),
    .early_thr_i (early_thr),
    .status_rd_i (status_rd_i),
    .active_o    (active),
    .early_o     (early_o),
    .mute_o      (mute_o),
    .valid_o     (atr_valid_o),
    .timeout_o   (timeout_o)
  );

  assign irq_o = early_o | mute_o;
endmodule

// File: rtl/atrw_checker.sv
`timescale 1ns/1ps
module atrw_checker
  import atrw_pkg::*;
(
  input logic clk_i,
  input logic rst_n,
  input logic start_i,
  input logic card_clk_en_i,
  input logic status_rd_i,
  input logic active,
  input logic at_limit,
  input cnt_t cnt,
  input logic early_o,
  input logic mute_o,
  input logic atr_valid_o,
  input logic timeout_o
);
  a_r3_count_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (active && !card_clk_en_i && !start_i) |=> $stable(cnt));

  a_r7_stops_at_limit: assert property (@(posedge clk_i) disable iff (!rst_n)
    (at_limit && !start_i) |=> $stable(cnt));

  a_r7_timeout_sets_mute: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> mute_o);

  a_r7_timeout_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    atr_valid_o |=> !atr_valid_o);

  a_r6_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(atr_valid_o && timeout_o));

  a_r8_early_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (early_o && !status_rd_i) |=> early_o);

  a_r8_mute_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mute_o && !status_rd_i) |=> mute_o);

  a_r10_start_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !status_rd_i && (early_o || mute_o)) |=> (early_o || mute_o));

  a_r7_no_run_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> (!active || $past(start_i)));
endmodule

bind atr_window_mon atrw_checker u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .card_clk_en_i (card_clk_en_i),
  .status_rd_i   (status_rd_i),
  .active        (active),
  .at_limit      (at_limit),
  .cnt           (cnt),
  .early_o       (early_o),
  .mute_o        (mute_o),
  .atr_valid_o   (atr_valid_o),
  .timeout_o     (timeout_o)
);

// File: tb/atr_window_mon_tb_top.sv
`timescale 1ns/1ps
module atr_window_mon_tb_top;
  localparam int K_EARLY = 1;
  localparam int K_VALID = 2;
  localparam int K_MUTE  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cke = 1'b1, io = 1'b1, rd = 1'b0;
  logic [7:0] e_hi = 8'h01, e_lo = 8'h40, m_hi = 8'h00, m_lo = 8'h40;
  logic early, mute, irq, valid, tout;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  logic early_prev = 1'b0;

  always #5 clk = ~clk;

  atr_window_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .card_clk_en_i(cke),
    .io_i(io), .status_rd_i(rd), .early_hi_i(e_hi), .early_lo_i(e_lo),
    .mute_hi_i(m_hi), .mute_lo_i(m_lo), .early_o(early), .mute_o(mute),
    .irq_o(irq), .atr_valid_o(valid), .timeout_o(tout));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int kind, input string what);
    int e;
    if (exp_q.size() == 0) begin
      check(1'b0, {"R4/R7 unexpected ", what}, kind, 0);
    end else begin
      e = exp_q.pop_front();
      check(e == kind, "R5/R6/R7 outcome kind", kind, e);
    end
  endtask

  // monitor: pops expected outcomes as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) observe(K_VALID, "valid");
      if (tout) observe(K_MUTE, "timeout");
      if (early && !early_prev) observe(K_EARLY, "early");
      early_prev = early;
    end
  end

  task automatic do_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic drop_io(input int m);
    repeat (m) @(posedge clk);
    #1 io = 1'b0;
    repeat (6) @(posedge clk);
    #1 io = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic clear_flags();
    @(posedge clk); #1 rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic run_fall(input int m, input int kind);
    exp_q.push_back(kind);
    do_start();
    drop_io(m);
  endtask

  task automatic run_mute(input int thr);
    exp_q.push_back(K_MUTE);
    do_start();
    repeat (thr) @(posedge clk);
    @(negedge clk);
    check(tout == 1'b0, "R7 timeout not before limit+1", tout, 0);
    @(posedge clk);
    @(negedge clk);
    check(tout == 1'b1 && mute == 1'b1, "R7 timeout and mute at limit+1", {tout, mute}, 3);
  endtask

  initial begin
    #1_500_000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({early, mute, irq, valid, tout} == 5'b0, "R1 reset state",
          {early, mute, irq, valid, tout}, 0);

    // R4: falls with no run in progress are ignored
    #1 io = 1'b0;
    repeat (6) @(posedge clk);
    #1 io = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(early == 1'b0 && mute == 1'b0, "R4 idle fall ignored", {early, mute}, 0);

    // early threshold {01, 01} = 5, mute threshold 64
    run_fall(2, K_EARLY);           // judged count 4
    @(negedge clk);
    check(early == 1'b1, "R5 early flag set", early, 1);
    check(irq == 1'b1 && mute == 1'b0, "R9 irq from early", {irq, mute}, 2);
    clear_flags();
    @(negedge clk);
    check(early == 1'b0 && irq == 1'b0, "R8 read clears flags", {early, irq}, 0);

    run_fall(3, K_VALID);           // judged count 5 equals threshold
    @(negedge clk);
    check(early == 1'b0, "R6 in-window sets no flag", early, 0);

    run_fall(61, K_VALID);          // judged count 63, last valid count
    @(negedge clk);
    check(mute == 1'b0, "R6 last count before mute", mute, 0);

    run_mute(64);
    check(irq == 1'b1, "R9 irq from mute", irq, 1);
    drop_io(2);                     // R7: no judgement after timeout
    @(negedge clk);
    check(early == 1'b0, "R7 fall after timeout ignored", early, 0);
    clear_flags();

    // R10: start keeps unread flags
    run_fall(2, K_EARLY);
    do_start();
    @(negedge clk);
    check(early == 1'b1, "R10 start keeps early flag", early, 1);
    exp_q.push_back(K_VALID);
    drop_io(4);
    clear_flags();

    // R8: event in the same cycle as a read wins
    exp_q.push_back(K_EARLY);
    do_start();
    repeat (1) @(posedge clk);
    #1 io = 1'b0;
    repeat (2) @(posedge clk);
    #1 rd = 1'b1;
    @(posedge clk);
    #1 rd = 1'b0;
    @(negedge clk);
    check(early == 1'b1, "R8 set wins over read", early, 1);
    repeat (4) @(posedge clk);
    #1 io = 1'b1;
    repeat (4) @(posedge clk);
    clear_flags();

    // R2: low bits [5:0] of the early low byte have no effect; threshold {01,00} = 4
    e_lo = 8'h3F;
    run_fall(1, K_EARLY);           // count 3
    clear_flags();
    run_fall(2, K_VALID);           // count 4
    @(negedge clk);
    check(early == 1'b0, "R2 unused low bits ignored", early, 0);

    // R3: count holds while card clock enable is low; mute threshold 5
    m_lo = 8'h05;
    exp_q.push_back(K_MUTE);
    #1 cke = 1'b0;
    do_start();
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(mute == 1'b0, "R3 no count without clock enable", mute, 0);
    @(posedge clk); #1 cke = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tout == 1'b0, "R3 five enabled edges reach limit only", tout, 0);
    @(posedge clk);
    @(negedge clk);
    check(tout == 1'b1, "R3 timeout after enabled count", tout, 1);
    clear_flags();

    // R2: register reset values, 680 and 42100
    e_hi = 8'hAA; e_lo = 8'h00; m_hi = 8'hA4; m_lo = 8'h74;
    run_fall(677, K_EARLY);         // count 679
    clear_flags();
    run_fall(678, K_VALID);         // count 680
    @(negedge clk);
    check(early == 1'b0, "R2 default early threshold 680", early, 0);
    run_mute(42100);
    clear_flags();

    repeat (5) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R5/R6/R7 all outcomes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule